// File: doc/BRIEF.md
# Multi-Mode Programmable Counter Channel

This block is one down-counting timer channel with a parameterised width (16 bits by default). It advances only on clocks where the count-clock enable `tick` is high. The host gives it a count value and a three-bit operating mode together on a single load strobe. A load value of zero is read as the full range, 2^CNT_W. From the number of enabled ticks since the last load or restart, the channel produces one of six output waveforms:
- a level that rises at terminal count;
- a retriggerable one-shot;
- a periodic one-tick rate pulse;
- a square wave;
- a single strobe started by the load;
- a single strobe started by the gate.

The live count appears on `cnt_now`. A latch strobe copies it into a holding register, which keeps its value until the host releases it. The gate input works in two ways depending on the mode. In some modes it pauses counting while low. In others a rising edge restarts the count from the loaded value. The gate edge detector comes out of reset with a level that depends on the channel's position, which is set by a parameter.

Top module: `timer_chan`

## Requirements
- R1: After reset the channel is in the square-wave mode (code 3) with a count of 2^CNT_W. `out` is high and `cnt_now` reads 0. The stored previous gate level is high for CHAN_ID 0 and 1 and low for CHAN_ID 2.
- R2: A `load` takes effect at the next edge and restarts the elapsed-tick count at zero. A `load_count` of 0 means 2^CNT_W. Mode codes 6 and 7 behave exactly like codes 2 and 3. `load` has priority over gate and tick in the same cycle.
- R3: Mode 0: `out` is low from the load until the elapsed ticks reach the count. It then stays high until the next load.
- R4: Mode 1: `out` is high while elapsed ticks are below the count and low from then on. Only a restart or a load changes it again.
- R5: Mode 2: `out` is high only while elapsed ticks equal a nonzero multiple of the count N, and low otherwise.
- R6: Mode 3: within each N-tick period, `out` is high for the first (N+1)/2 ticks and low for the rest. `cnt_now` reads N minus (2 × elapsed mod N), so it falls by 2 per tick.
- R7: Modes 4 and 5: `out` is high only while elapsed ticks equal the count. This happens once per load or restart.
- R8: In modes 0, 1, 4 and 5, `cnt_now` is (N − elapsed) mod 2^CNT_W. In mode 2 it is N − (elapsed mod N), truncated to CNT_W bits.
- R9: In modes 0, 2, 3 and 4, a tick with `gate` low does not advance the count. Modes 1 and 5 keep counting whatever the gate level.
- R10: In modes 1, 2, 3 and 5, a rising edge of `gate` (high now, low at the previous edge) restarts the elapsed count at zero with the loaded value.
- R11: `latch_req` while no value is held copies the current `cnt_now` into `cnt_latched` and sets `latch_valid`. Further requests leave it unchanged until `latch_rel`, which clears `latch_valid` and takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-clock enable, one elapsed tick per high cycle |
| gate | input | 1 | Gate level |
| load | input | 1 | Load strobe for count and mode |
| load_count | input | CNT_W | Count value, 0 means 2^CNT_W |
| load_mode | input | 3 | Operating mode code 0..7 |
| latch_req | input | 1 | Request to capture the live count |
| latch_rel | input | 1 | Release of the held count |
| out | output | 1 | Channel output waveform |
| cnt_now | output | CNT_W | Live readable count |
| cnt_latched | output | CNT_W | Held count |
| latch_valid | output | 1 | A held count is present |

## Verification
Every input is sampled at a rising edge, and `out` and `cnt_now` show the result of that edge with no further register stage. This applies to a load, a gate edge, a tick and a latch request alike. The latched copy holds the count as it stood before that edge. The bench drives stimulus on the falling edge and advances its reference elapsed-tick model at the rising edge. It compares `out`, `cnt_now` and the latch outputs at the following falling edge, one half period after the result is due.

// File: rtl/tc_pkg.sv
package tc_pkg;
   typedef enum logic [2:0] {
      M_TC_LEVEL  = 3'd0,
      M_ONE_SHOT  = 3'd1,
      M_RATE      = 3'd2,
      M_SQUARE    = 3'd3,
      M_SW_STROBE = 3'd4,
      M_HW_STROBE = 3'd5
   } tc_mode_e;

   // codes 6 and 7 alias the two periodic modes
   function automatic tc_mode_e fold_mode(input logic [2:0] code);
      if (code[2] & code[1]) return tc_mode_e'({1'b0, code[1:0]});
      return tc_mode_e'(code);
   endfunction

   function automatic logic is_periodic(input tc_mode_e m);
      return (m == M_RATE) || (m == M_SQUARE);
   endfunction

   function automatic logic gate_pauses(input tc_mode_e m);
      return (m == M_TC_LEVEL) || (m == M_RATE) || (m == M_SQUARE) || (m == M_SW_STROBE);
   endfunction

   function automatic logic gate_retriggers(input tc_mode_e m);
      return (m == M_ONE_SHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HW_STROBE);
   endfunction
endpackage

// File: rtl/tc_gate_edge.sv
module tc_gate_edge #(
   parameter bit RST_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_i,
   output logic rise_o
);
   logic gate_q;

   always_ff @(posedge clk) begin
      if (!rst_n) gate_q <= RST_LEVEL;
      else        gate_q <= gate_i;
   end

   assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/tc_core.sv
module tc_core
   import tc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             gate_i,
   input  logic             rise_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_cnt_i,
   input  logic [2:0]       load_mode_i,
   output tc_mode_e         mode_o,
   output logic [CNT_W:0]   n_o,
   output logic [CNT_W:0]   q_o,
   output logic             fired_o,
   output logic             at_tc_o,
   output logic             wrapped_o
);
   localparam int QW = CNT_W + 1;
   localparam logic [QW-1:0] FULL = QW'(1) << CNT_W;
   localparam logic [QW-1:0] ONE  = QW'(1);

   tc_mode_e        mode_q;
   logic [QW-1:0]   n_q, q_q, n_new;
   logic            fired_q, at_tc_q, wrapped_q;
   logic            adv, restart;

   assign n_new   = (load_cnt_i == '0) ? FULL : {1'b0, load_cnt_i};
   assign adv     = tick_i & (gate_i | ~gate_pauses(mode_q));
   assign restart = rise_i & gate_retriggers(mode_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= M_SQUARE;
         n_q       <= FULL;
         q_q       <= FULL;
         fired_q   <= 1'b0;
         at_tc_q   <= 1'b0;
         wrapped_q <= 1'b0;
      end else if (load_i) begin
         mode_q    <= fold_mode(load_mode_i);
         n_q       <= n_new;
         q_q       <= n_new;
         fired_q   <= 1'b0;
         at_tc_q   <= 1'b0;
         wrapped_q <= 1'b0;
      end else if (restart) begin
         q_q       <= n_q;
         fired_q   <= 1'b0;
         at_tc_q   <= 1'b0;
         wrapped_q <= 1'b0;
      end else if (adv) begin
         if (is_periodic(mode_q)) begin
            if (q_q == ONE) begin
               q_q       <= n_q;
               wrapped_q <= 1'b1;
            end else begin
               q_q <= q_q - ONE;
            end
         end else begin
            q_q     <= {1'b0, q_q[CNT_W-1:0] - 1'b1};
            at_tc_q <= 1'b0;
            if (!fired_q && q_q[CNT_W-1:0] == CNT_W'(1)) begin
               fired_q <= 1'b1;
               at_tc_q <= 1'b1;
            end
         end
      end
   end

   assign mode_o    = mode_q;
   assign n_o       = n_q;
   assign q_o       = q_q;
   assign fired_o   = fired_q;
   assign at_tc_o   = at_tc_q;
   assign wrapped_o = wrapped_q;

   // R9: a paused gate freezes the count in the gated modes
   p_gate_pause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_pauses(mode_q) && !gate_i && !load_i) |=> $stable(q_q));

   // R10: a qualifying gate edge reloads the phase counter
   p_gate_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !load_i) |=> (q_q == $past(n_q)));
endmodule

// File: rtl/tc_wave.sv
module tc_wave
   import tc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  tc_mode_e         mode_i,
   input  logic [CNT_W:0]   n_i,
   input  logic [CNT_W:0]   q_i,
   input  logic             fired_i,
   input  logic             at_tc_i,
   input  logic             wrapped_i,
   output logic             out_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam int DW = CNT_W + 2;

   logic [DW-1:0] dbl, nn, sq_rb;

   assign dbl   = {q_i, 1'b0};
   assign nn    = {1'b0, n_i};
   assign sq_rb = (dbl > nn) ? (dbl - nn) : dbl;

   always_comb begin
      out_o = 1'b0;
      cnt_o = q_i[CNT_W-1:0];
      unique case (mode_i)
         M_TC_LEVEL:  out_o = fired_i;
         M_ONE_SHOT:  out_o = ~fired_i;
         M_RATE:      out_o = wrapped_i && (q_i == n_i);
         M_SQUARE: begin
            out_o = q_i > (n_i >> 1);
            cnt_o = sq_rb[CNT_W-1:0];
         end
         default:     out_o = at_tc_i;
      endcase
   end
endmodule

// File: rtl/tc_count_latch.sv
module tc_count_latch #(
   parameter int CNT_W     = 16,
   parameter bit HOLD_ONCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             rel_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] held_o,
   output logic             valid_o
);
   logic [CNT_W-1:0] held_q;
   logic             valid_q;

   generate
      if (HOLD_ONCE) begin : g_hold_once
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               held_q  <= '0;
               valid_q <= 1'b0;
            end else if (rel_i) begin
               valid_q <= 1'b0;
            end else if (req_i && !valid_q) begin
               held_q  <= cnt_i;
               valid_q <= 1'b1;
            end
         end

         // R11: a held value is not overwritten before release
         p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_q && !rel_i) |=> ($stable(held_q) && valid_q));
      end else begin : g_overwrite
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               held_q  <= '0;
               valid_q <= 1'b0;
            end else if (rel_i) begin
               valid_q <= 1'b0;
            end else if (req_i) begin
               held_q  <= cnt_i;
               valid_q <= 1'b1;
            end
         end
      end
   endgenerate

   assign held_o  = held_q;
   assign valid_o = valid_q;
endmodule

// File: rtl/timer_chan.sv
module timer_chan
   import tc_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int CHAN_ID   = 0,
   parameter bit HOLD_ONCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             gate,
   input  logic             load,
   input  logic [CNT_W-1:0] load_count,
   input  logic [2:0]       load_mode,
   input  logic             latch_req,
   input  logic             latch_rel,
   output logic             out,
   output logic [CNT_W-1:0] cnt_now,
   output logic [CNT_W-1:0] cnt_latched,
   output logic             latch_valid
);
   localparam bit GATE_RST = (CHAN_ID != 2);

   generate
      if (CNT_W < 2 || CNT_W > 30) begin : g_bad_width
         $error("timer_chan: CNT_W out of range");
      end
      if (CHAN_ID < 0) begin : g_bad_chan
         $error("timer_chan: CHAN_ID must be non-negative");
      end
   endgenerate

   tc_mode_e       mode_w;
   logic [CNT_W:0] n_w, q_w;
   logic           fired_w, at_tc_w, wrapped_w, rise_w;

   tc_gate_edge #(.RST_LEVEL(GATE_RST)) u_edge (
      .clk(clk), .rst_n(rst_n), .gate_i(gate), .rise_o(rise_w)
   );

   tc_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .gate_i(gate), .rise_i(rise_w),
      .load_i(load), .load_cnt_i(load_count), .load_mode_i(load_mode),
      .mode_o(mode_w), .n_o(n_w), .q_o(q_w),
      .fired_o(fired_w), .at_tc_o(at_tc_w), .wrapped_o(wrapped_w)
   );

   tc_wave #(.CNT_W(CNT_W)) u_wave (
      .mode_i(mode_w), .n_i(n_w), .q_i(q_w),
      .fired_i(fired_w), .at_tc_i(at_tc_w), .wrapped_i(wrapped_w),
      .out_o(out), .cnt_o(cnt_now)
   );

   tc_count_latch #(.CNT_W(CNT_W), .HOLD_ONCE(HOLD_ONCE)) u_latch (
      .clk(clk), .rst_n(rst_n), .req_i(latch_req), .rel_i(latch_rel),
      .cnt_i(cnt_now), .held_o(cnt_latched), .valid_o(latch_valid)
   );

   // R2 / R8: a non-square load shows the loaded value on the next cycle
   p_load_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (load_mode == 3'd0 || load_mode == 3'd1 || load_mode == 3'd4 || load_mode == 3'd5))
      |=> (cnt_now == $past(load_count)));

   // R3: the terminal-count level never drops without a load
   p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w == M_TC_LEVEL && !load) |=> !$fell(out));

   // R4: a retrigger of the one-shot raises the output
   p_oneshot_retrig_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w == M_ONE_SHOT && rise_w && !load) |=> out);

   // R5: a rate pulse lasts one advancing tick when N exceeds 1
   p_rate_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w == M_RATE && out && tick && gate && !load && n_w > (CNT_W+1)'(1)) |=> !out);

   // R7: a strobe ends at the next advancing tick
   p_strobe_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_w == M_SW_STROBE || mode_w == M_HW_STROBE) && out && tick
       && (gate || mode_w == M_HW_STROBE) && !load) |=> !out);
endmodule

// File: tb/timer_chan_tb_top.sv
`timescale 1ns/1ps
module timer_chan_tb_top;
   localparam int W = 16;
   localparam int MASK = (1 << W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, gate = 1'b0, load = 1'b0, latch_req = 1'b0, latch_rel = 1'b0;
   logic [W-1:0] load_count = '0;
   logic [2:0]   load_mode = '0;
   logic         out, latch_valid;
   logic [W-1:0] cnt_now, cnt_latched;

   int n_checks = 0;
   int n_fail   = 0;

   // reference model state
   int  m_n = 1 << W;
   int  m_mode = 3;
   int  m_e = 0;
   bit  m_gprev = 1'b0;   // CHAN_ID 2 resets with the gate level low
   bit  m_lv = 1'b0;
   int  m_lval = 0;

   always #2.5 clk = ~clk;

   timer_chan #(.CNT_W(W), .CHAN_ID(2), .HOLD_ONCE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load(load),
      .load_count(load_count), .load_mode(load_mode),
      .latch_req(latch_req), .latch_rel(latch_rel),
      .out(out), .cnt_now(cnt_now), .cnt_latched(cnt_latched), .latch_valid(latch_valid)
   );

   function automatic bit ref_out();
      case (m_mode)
         0: return m_e >= m_n;
         1: return m_e < m_n;
         2: return (m_e % m_n == 0) && (m_e != 0);
         3: return (m_e % m_n) < ((m_n + 1) / 2);
         default: return m_e == m_n;
      endcase
   endfunction

   function automatic int ref_cnt();
      case (m_mode)
         2: return (m_n - (m_e % m_n)) & MASK;
         3: return (m_n - ((2 * m_e) % m_n)) & MASK;
         default: return (m_n - m_e) & MASK;
      endcase
   endfunction

   function automatic string out_tag();
      case (m_mode)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   task automatic compare_all();
      check(out_tag(), int'(out), int'(ref_out()));
      check((m_mode == 3) ? "R6" : "R8", int'(cnt_now), ref_cnt());
      check("R11", int'(latch_valid), int'(m_lv));
      if (m_lv) check("R11", int'(cnt_latched), m_lval);
   endtask

   // one cycle: inputs already driven at a falling edge
   task automatic cyc();
      int pre_cnt;
      bit pauses, retrig;
      pre_cnt = ref_cnt();
      @(posedge clk);
      pauses = (m_mode == 0 || m_mode == 2 || m_mode == 3 || m_mode == 4);
      retrig = (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5);
      if (load) begin
         m_n    = (load_count == 0) ? (1 << W) : int'(load_count);
         m_mode = (load_mode >= 6) ? int'(load_mode) - 4 : int'(load_mode);
         m_e    = 0;
      end else if (gate && !m_gprev && retrig) begin
         m_e = 0;
      end else if (tick && (gate || !pauses)) begin
         m_e++;
      end
      m_gprev = gate;
      if (latch_rel) m_lv = 1'b0;
      else if (latch_req && !m_lv) begin
         m_lv = 1'b1;
         m_lval = pre_cnt;
      end
      @(negedge clk);
      compare_all();
      load = 1'b0;
      latch_req = 1'b0;
      latch_rel = 1'b0;
   endtask

   task automatic run(input int cycles, input bit g, input int tick_mod);
      for (int i = 0; i < cycles; i++) begin
         gate = g;
         tick = (tick_mod <= 1) ? 1'b1 : ((i % tick_mod) != 0);
         cyc();
      end
   endtask

   task automatic do_load(input int cnt, input int mode);
      load = 1'b1;
      load_count = W'(cnt);
      load_mode = 3'(mode);
      tick = 1'b1;
      cyc();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, square mode, full count, output high
      check("R1", int'(out), 1);
      check("R1", int'(cnt_now), 0);
      compare_all();
      // R9: gate low pauses the square wave; R1: rising gate restarts (prev low)
      run(4, 1'b0, 1);
      run(10, 1'b1, 1);
      // R3 with a gate pause in the middle, R8 readback wraps past zero
      do_load(5, 0);
      run(3, 1'b1, 1);
      run(3, 1'b0, 1);
      run(8, 1'b1, 3);
      // R4: one-shot runs out, gate edge retriggers (R10)
      do_load(4, 1);
      run(7, 1'b1, 1);
      run(2, 1'b0, 1);
      run(8, 1'b1, 2);
      // R5: rate pulses, N=3 and N=1
      do_load(3, 2);
      run(14, 1'b1, 1);
      run(3, 1'b0, 1);
      run(6, 1'b1, 1);
      do_load(1, 2);
      run(5, 1'b1, 1);
      // R6: odd and even square waves, with restart mid period
      do_load(5, 3);
      run(17, 1'b1, 1);
      do_load(4, 3);
      run(6, 1'b1, 1);
      run(1, 1'b0, 1);
      run(12, 1'b1, 3);
      // R7: software strobe, hardware strobe with retrigger
      do_load(3, 4);
      run(8, 1'b1, 1);
      do_load(3, 5);
      run(6, 1'b0, 1);
      run(1, 1'b0, 1);
      run(6, 1'b1, 1);
      // R2: alias codes 6 and 7, and zero meaning full range
      do_load(4, 6);
      run(10, 1'b1, 1);
      do_load(3, 7);
      run(9, 1'b1, 1);
      do_load(0, 0);
      check("R2", int'(cnt_now), 0);
      run(4, 1'b1, 1);
      // R2: load wins over a gate edge in the same cycle
      gate = 1'b0;
      run(1, 1'b0, 1);
      gate = 1'b1;
      do_load(6, 5);
      run(4, 1'b1, 1);
      // R11: latch, ignored second request, release, re-latch
      do_load(7, 2);
      run(2, 1'b1, 1);
      latch_req = 1'b1;
      run(1, 1'b1, 1);
      run(3, 1'b1, 1);
      latch_req = 1'b1;
      run(1, 1'b1, 1);
      run(2, 1'b1, 1);
      latch_rel = 1'b1;
      latch_req = 1'b1;
      run(1, 1'b1, 1);
      latch_req = 1'b1;
      run(1, 1'b1, 1);
      run(3, 1'b1, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule